// File: doc/BRIEF.md
# Precise Exception Retirement Unit

This block watches the oldest instruction of an in-order-retiring pipeline as it leaves the machine and decides whether control must move to an exception handler. Each retiring slot carries its PC, its architectural next PC, an exception flag, a two-bit class code and a vector number. Exceptions are recognised only at retirement, so they are taken strictly in program order.

When an excepting slot is accepted, the block flushes every younger instruction in the same cycle. It then stops taking slots until the store buffer reports empty, and issues a one-cycle handler redirect carrying the vector. The restart address it saves depends on the class. A fault saves its own PC. A trap saves its next PC, which for a taken jump is the jump target. An abort saves nothing restartable and raises a sticky fatal flag. A return-from-handler strobe redirects fetch to the saved PC and clears the exception-in-progress flag.

The retiring slot is a valid/ready stream. The producer must hold `ret_valid` and the slot fields stable until a cycle in which `ret_ready` is high. `ret_ready` is low while the block waits for stores to drain and during the redirect cycle. All other pins are plain levels or single-cycle pulses.

Top module: `exc_retire_unit`

## Requirements
- R1: `flush` is high in exactly the cycle in which a slot with `ret_exc`=1 is accepted (`ret_valid` and `ret_ready` both high), and low otherwise.
- R2: `ret_commit` is high in a cycle where a slot is accepted with `ret_exc`=0 or with class code 1 (trap). An accepted fault (code 0) or abort (code 2 or 3) does not commit.
- R3: After a fault (class code 0) is accepted, `epc` equals that slot's `ret_pc` and `epc_valid` is 1 from the next cycle on.
- R4: After a trap (class code 1) is accepted, `epc` equals that slot's `ret_npc` (the jump target for a taken jump) and `epc_valid` is 1 from the next cycle on.
- R5: After an abort (class code 2, or reserved code 3) is accepted, `fatal` is 1 from the next cycle until reset and `epc_valid` is 0. A return strobe in that state has no effect: no `resume_valid` is issued and `exc_active` stays 1.
- R6: `hnd_valid` pulses for exactly one cycle. It rises in the cycle after a rising clock edge at which the block was waiting for drain and `sb_empty` was 1. While `sb_empty` stays 0 the pulse is withheld.
- R7: `hnd_vec` equals the `ret_vec` of the accepted exception, so a software interrupt with operand n presents n.
- R8: When `hret` is 1 in a cycle where the handler is running, `epc_valid` is 1 and no exception is accepted in that cycle, `resume_valid` pulses in the next cycle with `resume_pc` equal to `epc`, and `exc_active` drops to 0. Otherwise `hret` has no effect; an exception accepted in the same cycle takes precedence.
- R9: `ret_ready` is 0 from the cycle after an exception is accepted through the `hnd_valid` cycle, and 1 at all other times. `exc_active` is 1 from the cycle after the exception is accepted until the resume pulse.
- R10: After reset, `ret_ready` is 1, and `flush`, `hnd_valid`, `epc_valid`, `fatal`, `exc_active` and `resume_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Retiring slot present |
| ret_ready | output | 1 | Block accepts the slot this cycle |
| ret_pc | input | PC_W | PC of the retiring instruction |
| ret_npc | input | PC_W | Architectural next PC (jump target if taken) |
| ret_exc | input | 1 | Slot raised an exception |
| ret_cls | input | 2 | Class code: 0 fault, 1 trap, 2 abort, 3 treated as abort |
| ret_vec | input | VEC_W | Exception vector number |
| ret_commit | output | 1 | Accepted slot updates architectural state |
| flush | output | 1 | Kill all younger instructions |
| sb_empty | input | 1 | No older store is outstanding |
| hnd_valid | output | 1 | One-cycle redirect to handler |
| hnd_vec | output | VEC_W | Vector of the exception being taken |
| epc | output | PC_W | Saved restart address |
| epc_valid | output | 1 | Saved address is restartable |
| fatal | output | 1 | Sticky abort indication |
| exc_active | output | 1 | Exception in progress |
| hret | input | 1 | Return-from-handler strobe |
| resume_valid | output | 1 | One-cycle redirect back to saved address |
| resume_pc | output | PC_W | Address for the resume redirect |

## Verification
The slot stream is driven through several kinds of traffic. Plain retirements show that nothing is flushed. A fault held behind a store buffer that stays busy for several cycles separates the fault restart address from the trap address and shows the drain wait. A trap whose next PC is a distant jump target, carrying a software vector, confirms that the target rather than PC+4 is saved. A younger slot held valid during drain exercises back-pressure. A return strobe issued while idle, and another issued in the same cycle as a new exception, show that `hret` is ignored in those cases. An abort, a reserved class code and a later reset show that the fatal flag is sticky and that no resume is issued.

// File: rtl/exc_retire_pkg.sv
package exc_retire_pkg;
  typedef enum logic [1:0] {
    CLS_FAULT = 2'd0,
    CLS_TRAP  = 2'd1,
    CLS_ABORT = 2'd2,
    CLS_RSVD  = 2'd3
  } exc_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_GO    = 2'd2,
    ST_HND   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_retire_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            fire,
  input  logic            exc,
  input  logic [1:0]      cls,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] npc,
  output logic            take,
  output logic            commit,
  output logic            restartable,
  output logic [PC_W-1:0] restart_pc
);
  exc_cls_e kind;

  always_comb begin
    kind        = exc_cls_e'(cls);
    take        = fire & exc;
    restartable = 1'b0;
    restart_pc  = pc;
    unique case (kind)
      CLS_FAULT: begin
        restartable = 1'b1;
        restart_pc  = pc;
      end
      CLS_TRAP: begin
        restartable = 1'b1;
        restart_pc  = npc;
      end
      default: begin
        restartable = 1'b0;
        restart_pc  = pc;
      end
    endcase
    commit = fire & (~exc | (kind == CLS_TRAP));
  end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_retire_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sb_empty,
  input  logic hret,
  input  logic saved_ok,
  output logic ready,
  output logic hnd_go,
  output logic active,
  output logic resume_fire
);
  seq_st_e st_q, st_d;

  always_comb begin
    ready       = (st_q == ST_IDLE) || (st_q == ST_HND);
    hnd_go      = (st_q == ST_GO);
    active      = (st_q != ST_IDLE);
    resume_fire = hret & (st_q == ST_HND) & ~take & saved_ok;
    st_d        = st_q;
    unique case (st_q)
      ST_IDLE:  st_d = ST_IDLE;
      ST_DRAIN: if (sb_empty) st_d = ST_GO;
      ST_GO:    st_d = ST_HND;
      ST_HND:   if (resume_fire) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (take) st_d = ST_DRAIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/exc_ctx_reg.sv
module exc_ctx_reg #(
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restartable,
  input  logic [PC_W-1:0]  restart_pc,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             resume_fire,
  output logic [PC_W-1:0]  epc,
  output logic             epc_valid,
  output logic [VEC_W-1:0] vec,
  output logic             fatal,
  output logic             resume_valid,
  output logic [PC_W-1:0]  resume_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc       <= '0;
      epc_valid <= 1'b0;
      vec       <= '0;
      fatal     <= 1'b0;
    end else if (take) begin
      vec       <= vec_in;
      epc_valid <= restartable;
      if (restartable) epc <= restart_pc;
      else             fatal <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_valid <= 1'b0;
      resume_pc    <= '0;
    end else begin
      resume_valid <= resume_fire;
      if (resume_fire) resume_pc <= epc;
    end
  end
endmodule

// File: rtl/exc_retire_unit.sv
module exc_retire_unit #(
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  output logic             ret_ready,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [PC_W-1:0]  ret_npc,
  input  logic             ret_exc,
  input  logic [1:0]       ret_cls,
  input  logic [VEC_W-1:0] ret_vec,
  output logic             ret_commit,
  output logic             flush,
  input  logic             sb_empty,
  output logic             hnd_valid,
  output logic [VEC_W-1:0] hnd_vec,
  output logic [PC_W-1:0]  epc,
  output logic             epc_valid,
  output logic             fatal,
  output logic             exc_active,
  input  logic             hret,
  output logic             resume_valid,
  output logic [PC_W-1:0]  resume_pc
);
  logic            fire, take, restartable, resume_fire;
  logic [PC_W-1:0] restart_pc;

  assign fire  = ret_valid & ret_ready;
  assign flush = take;

  exc_classify #(.PC_W(PC_W)) u_cls (
    .fire(fire), .exc(ret_exc), .cls(ret_cls), .pc(ret_pc), .npc(ret_npc),
    .take(take), .commit(ret_commit), .restartable(restartable),
    .restart_pc(restart_pc)
  );

  exc_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .sb_empty(sb_empty), .hret(hret),
    .saved_ok(epc_valid), .ready(ret_ready), .hnd_go(hnd_valid),
    .active(exc_active), .resume_fire(resume_fire)
  );

  exc_ctx_reg #(.PC_W(PC_W), .VEC_W(VEC_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .take(take), .restartable(restartable),
    .restart_pc(restart_pc), .vec_in(ret_vec), .resume_fire(resume_fire),
    .epc(epc), .epc_valid(epc_valid), .vec(hnd_vec), .fatal(fatal),
    .resume_valid(resume_valid), .resume_pc(resume_pc)
  );
endmodule

// File: rtl/exc_retire_chk.sv
module exc_retire_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ret_valid,
  input logic       ret_ready,
  input logic       ret_exc,
  input logic [1:0] ret_cls,
  input logic       flush,
  input logic       sb_empty,
  input logic       hnd_valid,
  input logic       epc_valid,
  input logic       fatal,
  input logic       exc_active,
  input logic       hret,
  input logic       resume_valid
);
  // R1
  flush_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid && ret_ready && ret_exc));
  // R9
  stall_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ret_ready && exc_active));
  // R6
  drain_before_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid |-> $past(sb_empty));
  // R6
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid |=> !hnd_valid);
  // R5
  abort_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && ret_cls[1]) |=> (fatal && !epc_valid));
  // R5
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  // R8
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> ($past(hret) && !exc_active));
endmodule

bind exc_retire_unit exc_retire_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
  .ret_exc(ret_exc), .ret_cls(ret_cls), .flush(flush), .sb_empty(sb_empty),
  .hnd_valid(hnd_valid), .epc_valid(epc_valid), .fatal(fatal),
  .exc_active(exc_active), .hret(hret), .resume_valid(resume_valid)
);

// File: tb/exc_retire_unit_tb.sv
`timescale 1ns/1ps
module exc_retire_unit_tb;
  localparam int PC_W = 32;
  localparam int VEC_W = 8;

  logic clk = 0, rst_n = 0;
  logic ret_valid = 0, ret_exc = 0, sb_empty = 1, hret = 0;
  logic [PC_W-1:0] ret_pc = 0, ret_npc = 0;
  logic [1:0] ret_cls = 0;
  logic [VEC_W-1:0] ret_vec = 0;
  logic ret_ready, ret_commit, flush, hnd_valid, epc_valid, fatal, exc_active, resume_valid;
  logic [VEC_W-1:0] hnd_vec;
  logic [PC_W-1:0] epc, resume_pc;

  always #5 clk = ~clk;

  exc_retire_unit #(.PC_W(PC_W), .VEC_W(VEC_W)) u_dut (.*);

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  // behavioural reference: 0 idle, 1 drain, 2 redirect, 3 handler
  int m_st = 0;
  longint m_epc = 0, m_rpc = 0;
  int m_vec = 0, m_cls = 0;
  bit m_epcv = 0, m_fatal = 0, m_resv = 0;

  function automatic bit m_ready();
    return (m_st == 0) || (m_st == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_epc = 0; m_rpc = 0; m_vec = 0; m_epcv = 0; m_fatal = 0; m_resv = 0;
    end else begin
      bit tk, rf;
      tk = ret_valid && m_ready() && ret_exc;
      rf = hret && (m_st == 3) && !tk && m_epcv;
      m_resv = rf;
      if (rf) begin m_rpc = m_epc; m_st = 0; end
      else if (m_st == 1 && sb_empty) m_st = 2;
      else if (m_st == 2) m_st = 3;
      if (tk) begin
        m_st = 1; m_vec = ret_vec; m_cls = ret_cls;
        if (ret_cls == 0)      begin m_epc = ret_pc;  m_epcv = 1; end
        else if (ret_cls == 1) begin m_epc = ret_npc; m_epcv = 1; end
        else begin m_epcv = 0; m_fatal = 1; end
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      bit rdy, acc;
      rdy = m_ready();
      acc = ret_valid && rdy;
      chk("R9 ret_ready", ret_ready, rdy);
      chk("R1 flush", flush, acc && ret_exc);
      chk("R2 ret_commit", ret_commit, acc && (!ret_exc || ret_cls == 1));
      chk("R6 hnd_valid", hnd_valid, m_st == 2);
      if (m_st == 2) chk("R7 hnd_vec", hnd_vec, m_vec);
      chk("R5 epc_valid", epc_valid, m_epcv);
      if (m_epcv) chk(m_cls == 0 ? "R3 epc" : "R4 epc", epc, m_epc);
      chk("R5 fatal", fatal, m_fatal);
      chk("R9 exc_active", exc_active, m_st != 0);
      chk("R8 resume_valid", resume_valid, m_resv);
      if (m_resv) chk("R8 resume_pc", resume_pc, m_rpc);
    end
    if (cyc > 20000 && !done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(bit e, int c, longint pc, longint npc, int v);
    bit acc;
    ret_valid = 1; ret_exc = e; ret_cls = c[1:0]; ret_pc = pc[PC_W-1:0];
    ret_npc = npc[PC_W-1:0]; ret_vec = v[VEC_W-1:0];
    do begin
      @(negedge clk); acc = ret_ready;
      @(posedge clk); #1;
    end while (!acc);
    ret_valid = 0; ret_exc = 0;
  endtask

  task automatic pulse_hret();
    hret = 1; step(); hret = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(2); rst_n = 1;
    @(negedge clk);
    // R10 reset values
    chk("R10 ready", ret_ready, 1);
    chk("R10 idle", {hnd_valid, epc_valid, fatal, exc_active, resume_valid, flush}, 0);
    step();
  endtask

  initial begin
    step(); do_reset();
    // plain retirements
    send(0, 0, 'h10, 'h14, 0);
    send(0, 2, 'h14, 'h18, 0);
    // fault behind a busy store buffer, younger slot held (R3, R6, R9)
    sb_empty = 0;
    send(1, 0, 'h100, 'h104, 14);
    fork
      send(0, 0, 'h104, 'h108, 0);
      begin step(4); sb_empty = 1; end
    join
    step(2); pulse_hret(); step(3);
    // hret while idle is ignored (R8)
    pulse_hret(); step(2);
    // software interrupt trap on a taken jump (R4, R7)
    send(1, 1, 'h200, 'h8000, 'h80);
    step(4); pulse_hret(); step(2);
    // exception in handler with simultaneous return (R8 precedence)
    send(1, 0, 'h300, 'h304, 5);
    step(4);
    fork
      send(1, 1, 'h400, 'h440, 6);
      pulse_hret();
    join
    step(4); pulse_hret(); step(2);
    // abort: sticky fatal, return ignored (R5)
    send(1, 2, 'h500, 'h504, 8);
    step(4); pulse_hret(); step(3);
    send(0, 0, 'h600, 'h604, 0);
    step(2);
    do_reset();
    // reserved class code behaves as abort (R5)
    send(1, 3, 'h700, 'h704, 9);
    step(4); pulse_hret(); step(3);
    do_reset();
    send(0, 1, 'h800, 'h900, 0);
    step(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule